// File: doc/BRIEF.md
# JTAG Debug Port Scan Chain

This block is the target side of a JTAG debug port. It sits behind a standard TAP controller, which supplies one-cycle state strobes for capture, shift and update of both the instruction and data paths. The block holds a 4-bit instruction register. Based on that register, it routes TDI through one of five data chains to TDO: a one-bit bypass cell, a read-only identification word, two 35-bit access chains (one for debug-port registers, one for access-port registers) and an abort chain.

Scanning data into an access chain launches a request on a downstream request port. The request carries 32-bit write data, a 2-bit register address, a read/write flag and a port selector. The next scan through an access chain captures the outcome of that request: the latched read data and a 3-bit acknowledge. A small link state machine with two states tracks whether a request is outstanding. LINK_IDLE moves to LINK_BUSY when a request is issued. LINK_BUSY returns to LINK_IDLE when the downstream side reports completion or when an abort is requested.

When the access chain is captured during LINK_BUSY, the acknowledge reads wait, and the update at the end of that scan issues no request. Writing a 1 to bit 0 of the abort chain produces a one-cycle abort pulse and drops the outstanding request.

Top module: `jtag_dp_scan`

## Requirements
- R1: The instruction register is 4 bits wide. Capture-IR loads the shift stage with 4'b0001. Shift-IR shifts TDI into the MSB, and update-IR makes the shifted value current. Reset makes code 4'b1110 (identification) current.
- R2: With code 4'b1110 current, capture-DR loads the 32-bit chain with 32'h3BA00477. The chain is shifted out LSB first.
- R3: Code 4'b1111 selects a 1-bit bypass cell that captures 0. Any code other than 4'b1110, 4'b1010, 4'b1011 and 4'b1000 also selects the bypass cell, so TDI appears on TDO one shift later.
- R4: Codes 4'b1010 and 4'b1011 select a 35-bit access chain. The bits shifted in are laid out as write data in [34:3], register address in [2:1] and read/write flag in [0], where 1 means read. The request carries req_ap=0 for code 4'b1010 and req_ap=1 for code 4'b1011.
- R5: req_valid pulses for exactly one cycle, in the cycle after update-DR. It pulses only when an access chain is selected and that scan did not capture wait. A scan through the identification or bypass chain issues no request.
- R6: Capture-DR on an access chain loads {held read data, ack}. The ack is 3'b010 (OK) when no request is outstanding and 3'b001 (wait) when one is. The held read data is taken from rsp_rdata when rsp_valid is high while a request is outstanding, and it resets to zero.
- R7: A scan that captured wait issues no request at its update-DR, and the outstanding request stays outstanding.
- R8: Code 4'b1000 selects a 32-bit abort chain that captures zero. Update-DR with bit 0 set gives a one-cycle abort_pulse and ends any outstanding request. With bit 0 clear, update-DR has no effect.
- R9: The link moves from LINK_IDLE to LINK_BUSY on issuing a request. It moves from LINK_BUSY to LINK_IDLE on rsp_valid or on an abort. rsp_valid is ignored in LINK_IDLE.
- R10: TDO shows the LSB of the instruction shift stage during shift-IR, and the LSB of the data chain at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test-logic reset |
| capture_ir | input | 1 | TAP strobe: capture instruction |
| shift_ir | input | 1 | TAP strobe: shift instruction |
| update_ir | input | 1 | TAP strobe: update instruction |
| capture_dr | input | 1 | TAP strobe: capture data |
| shift_dr | input | 1 | TAP strobe: shift data |
| update_dr | input | 1 | TAP strobe: update data |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| req_valid | output | 1 | One-cycle request strobe |
| req_ap | output | 1 | 1: access-port request, 0: debug-port request |
| req_addr | output | 2 | Register address bits |
| req_rnw | output | 1 | 1: read, 0: write |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Outstanding request completed |
| rsp_rdata | input | 32 | Read data of completed request |
| abort_pulse | output | 1 | One-cycle abort strobe |

## Verification
Every cycle, the assertions check that request and abort strobes last one cycle, follow an update-DR and never coincide. They also check that a request only follows an access-chain selection and leaves the link busy, that an abort leaves it idle, and that the link only leaves LINK_BUSY on a response or an abort. Only the bench scenarios can show the serial contents: the identification word, bypass delay, unknown-code fallback, wait-then-OK acknowledge sequence, field placement of issued requests, and that responses arriving in LINK_IDLE leave the held read data unchanged.

// File: rtl/jds_pkg.sv
package jds_pkg;
    localparam int ACK_W = 3;
    localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
    localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

    typedef enum logic [2:0] {
        SEL_BYPASS,
        SEL_IDCODE,
        SEL_DPACC,
        SEL_APACC,
        SEL_ABORT
    } dr_sel_t;

    typedef enum logic {
        LINK_IDLE,
        LINK_BUSY
    } link_state_t;
endpackage

// File: rtl/jds_ir.sv
module jds_ir
    import jds_pkg::*;
#(
    parameter int IR_W = 4,
    parameter logic [IR_W-1:0] CODE_IDCODE = 4'b1110,
    parameter logic [IR_W-1:0] CODE_BYPASS = 4'b1111,
    parameter logic [IR_W-1:0] CODE_DPACC  = 4'b1010,
    parameter logic [IR_W-1:0] CODE_APACC  = 4'b1011,
    parameter logic [IR_W-1:0] CODE_ABORT  = 4'b1000
) (
    input  logic    tck,
    input  logic    trst_n,
    input  logic    capture_ir,
    input  logic    shift_ir,
    input  logic    update_ir,
    input  logic    tdi,
    output logic    ir_lsb,
    output dr_sel_t sel
);
    logic [IR_W-1:0] ir_sr_q;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr_q <= '0;
            ir_q    <= CODE_IDCODE;
        end else begin
            if (capture_ir)
                ir_sr_q <= IR_W'(1);
            else if (shift_ir)
                ir_sr_q <= {tdi, ir_sr_q[IR_W-1:1]};
            if (update_ir)
                ir_q <= ir_sr_q;
        end
    end

    assign ir_lsb = ir_sr_q[0];

    always_comb begin
        if (ir_q == CODE_IDCODE)      sel = SEL_IDCODE;
        else if (ir_q == CODE_DPACC)  sel = SEL_DPACC;
        else if (ir_q == CODE_APACC)  sel = SEL_APACC;
        else if (ir_q == CODE_ABORT)  sel = SEL_ABORT;
        else if (ir_q == CODE_BYPASS) sel = SEL_BYPASS;
        else                          sel = SEL_BYPASS;
    end
endmodule

// File: rtl/jds_dr.sv
module jds_dr
    import jds_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ABORT_W = 32,
    parameter int          ID_W    = 32,
    parameter logic [31:0] IDCODE  = 32'h3BA00477,
    localparam int         CHAIN_W = DATA_W + ACK_W,
    localparam int         LEN_W   = $clog2(CHAIN_W + 1)
) (
    input  logic               tck,
    input  logic               trst_n,
    input  dr_sel_t            sel,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               tdi,
    input  logic [ACK_W-1:0]   ack,
    input  logic [DATA_W-1:0]  rdata,
    output logic [CHAIN_W-1:0] sr
);
    logic [CHAIN_W-1:0] sr_q;
    logic [CHAIN_W-1:0] shifted;
    logic [CHAIN_W-1:0] cap_val;
    logic [LEN_W-1:0]   len;

    always_comb begin
        unique case (sel)
            SEL_IDCODE:           len = LEN_W'(ID_W);
            SEL_DPACC, SEL_APACC: len = LEN_W'(CHAIN_W);
            SEL_ABORT:            len = LEN_W'(ABORT_W);
            default:              len = LEN_W'(1);
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_IDCODE:           cap_val = CHAIN_W'(IDCODE);
            SEL_DPACC, SEL_APACC: cap_val = {rdata, ack};
            default:              cap_val = '0;
        endcase
    end

    always_comb begin
        shifted = {1'b0, sr_q[CHAIN_W-1:1]};
        for (int i = 0; i < CHAIN_W; i++)
            if (LEN_W'(i) == len - LEN_W'(1))
                shifted[i] = tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            sr_q <= '0;
        else if (capture_dr)
            sr_q <= cap_val;
        else if (shift_dr)
            sr_q <= shifted;
    end

    assign sr = sr_q;
endmodule

// File: rtl/jds_link.sv
module jds_link
    import jds_pkg::*;
#(
    parameter int  DATA_W  = 32,
    localparam int ADDR_W  = ACK_W - 1,
    localparam int CHAIN_W = DATA_W + ACK_W
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               capture_dr,
    input  logic               update_dr,
    input  logic               is_access,
    input  logic               is_ap,
    input  logic               is_abort,
    input  logic [CHAIN_W-1:0] sr,
    input  logic               rsp_valid,
    input  logic [DATA_W-1:0]  rsp_rdata,
    output logic [ACK_W-1:0]   ack,
    output logic [DATA_W-1:0]  rdata_hold,
    output logic               busy,
    output logic               req_valid,
    output logic               req_ap,
    output logic [ADDR_W-1:0]  req_addr,
    output logic               req_rnw,
    output logic [DATA_W-1:0]  req_wdata,
    output logic               abort_pulse
);
    link_state_t state_q, state_d;
    logic        wait_q;
    logic        issue;
    logic        abort_req;

    assign issue     = update_dr && is_access && !wait_q;
    assign abort_req = update_dr && is_abort && sr[0];
    assign busy      = (state_q == LINK_BUSY);
    assign ack       = busy ? ACK_WAIT : ACK_OK;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_IDLE: if (issue) state_d = LINK_BUSY;
            LINK_BUSY: if (abort_req || rsp_valid) state_d = LINK_IDLE;
            default:   state_d = LINK_IDLE;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= LINK_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            wait_q      <= 1'b0;
            rdata_hold  <= '0;
            req_valid   <= 1'b0;
            req_ap      <= 1'b0;
            req_addr    <= '0;
            req_rnw     <= 1'b0;
            req_wdata   <= '0;
            abort_pulse <= 1'b0;
        end else begin
            req_valid   <= issue;
            abort_pulse <= abort_req;
            if (abort_req)
                wait_q <= 1'b0;
            else if (capture_dr && is_access)
                wait_q <= busy;
            if (busy && rsp_valid)
                rdata_hold <= rsp_rdata;
            if (issue) begin
                req_ap    <= is_ap;
                req_addr  <= sr[ACK_W-1:1];
                req_rnw   <= sr[0];
                req_wdata <= sr[CHAIN_W-1:ACK_W];
            end
        end
    end
endmodule

// File: rtl/jtag_dp_scan.sv
module jtag_dp_scan
    import jds_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          IR_W    = 4,
    parameter int          ABORT_W = 32,
    parameter logic [31:0] IDCODE  = 32'h3BA00477,
    localparam int         ADDR_W  = ACK_W - 1,
    localparam int         CHAIN_W = DATA_W + ACK_W
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              capture_ir,
    input  logic              shift_ir,
    input  logic              update_ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic              req_valid,
    output logic              req_ap,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_rnw,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              abort_pulse
);
    dr_sel_t            sel;
    logic               ir_lsb;
    logic [CHAIN_W-1:0] dr_sr;
    logic [ACK_W-1:0]   ack;
    logic [DATA_W-1:0]  rdata_hold;
    logic               link_busy;
    logic               sel_is_access;

    assign sel_is_access = (sel == SEL_DPACC) || (sel == SEL_APACC);

    jds_ir #(.IR_W(IR_W)) u_ir (
        .tck(tck), .trst_n(trst_n), .capture_ir(capture_ir),
        .shift_ir(shift_ir), .update_ir(update_ir), .tdi(tdi),
        .ir_lsb(ir_lsb), .sel(sel)
    );

    jds_dr #(.DATA_W(DATA_W), .ABORT_W(ABORT_W), .IDCODE(IDCODE)) u_dr (
        .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .tdi(tdi), .ack(ack), .rdata(rdata_hold),
        .sr(dr_sr)
    );

    jds_link #(.DATA_W(DATA_W)) u_link (
        .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr),
        .update_dr(update_dr), .is_access(sel_is_access),
        .is_ap(sel == SEL_APACC), .is_abort(sel == SEL_ABORT),
        .sr(dr_sr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ack(ack), .rdata_hold(rdata_hold), .busy(link_busy),
        .req_valid(req_valid), .req_ap(req_ap), .req_addr(req_addr),
        .req_rnw(req_rnw), .req_wdata(req_wdata), .abort_pulse(abort_pulse)
    );

    assign tdo = shift_ir ? ir_lsb : dr_sr[0];
endmodule

// File: rtl/jds_chk.sv
module jds_chk (
    input logic tck,
    input logic trst_n,
    input logic update_dr,
    input logic req_valid,
    input logic abort_pulse,
    input logic rsp_valid,
    input logic busy,
    input logic sel_access
);
    assert_req_after_update_R5: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |-> $past(update_dr));
    assert_req_single_R5: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |=> !req_valid);
    assert_req_abort_excl_R5: assert property (@(posedge tck) disable iff (!trst_n)
        !(req_valid && abort_pulse));
    assert_req_from_access_R4: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |-> $past(sel_access));
    assert_req_busy_R9: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |-> busy);
    assert_abort_idle_R8: assert property (@(posedge tck) disable iff (!trst_n)
        abort_pulse |-> ($past(update_dr) && !busy));
    assert_abort_single_R8: assert property (@(posedge tck) disable iff (!trst_n)
        abort_pulse |=> !abort_pulse);
    assert_busy_release_R9: assert property (@(posedge tck) disable iff (!trst_n)
        $fell(busy) |-> ($past(rsp_valid) || abort_pulse));
endmodule

bind jtag_dp_scan jds_chk u_chk (
    .tck(tck), .trst_n(trst_n), .update_dr(update_dr),
    .req_valid(req_valid), .abort_pulse(abort_pulse),
    .rsp_valid(rsp_valid), .busy(link_busy), .sel_access(sel_is_access)
);

// File: tb/jtag_dp_scan_tb_top.sv
`timescale 1ns/1ps
module jtag_dp_scan_tb_top;
    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        capture_ir = 0, shift_ir = 0, update_ir = 0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic        tdi = 0;
    logic        tdo;
    logic        req_valid, req_ap, req_rnw, abort_pulse;
    logic [1:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 0;
    logic [31:0] rsp_rdata = '0;

    int checks = 0;
    int errors = 0;
    int abort_cnt = 0;
    bit done = 0;
    logic [35:0] exp_q[$];   // {ap, addr[1:0], rnw, wdata[31:0]}

    always #2.5 tck = ~tck;

    jtag_dp_scan dut_i (
        .tck(tck), .trst_n(trst_n), .capture_ir(capture_ir), .shift_ir(shift_ir),
        .update_ir(update_ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .req_valid(req_valid),
        .req_ap(req_ap), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .abort_pulse(abort_pulse)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected requests and compares them as they appear.
    always @(negedge tck) begin
        if (trst_n && req_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected request", {28'h0, req_ap, req_addr, req_rnw, req_wdata}, 64'h0);
            end else begin
                logic [35:0] e;
                e = exp_q.pop_front();
                check({req_ap, req_addr, req_rnw, req_wdata} == e, "R4 request fields",
                      {28'h0, req_ap, req_addr, req_rnw, req_wdata}, {28'h0, e});
            end
        end
        if (trst_n && abort_pulse) abort_cnt++;
    end

    task automatic scan_ir(logic [3:0] code, output logic [3:0] dout);
        @(negedge tck); capture_ir = 1;
        @(negedge tck); capture_ir = 0; shift_ir = 1;
        for (int i = 0; i < 4; i++) begin
            tdi = code[i]; #1 dout[i] = tdo;
            @(negedge tck);
        end
        shift_ir = 0; update_ir = 1;
        @(negedge tck); update_ir = 0;
    endtask

    task automatic scan_dr(int len, logic [34:0] din, output logic [34:0] dout);
        dout = '0;
        @(negedge tck); capture_dr = 1;
        @(negedge tck); capture_dr = 0; shift_dr = 1;
        for (int i = 0; i < len; i++) begin
            tdi = din[i]; #1 dout[i] = tdo;
            @(negedge tck);
        end
        shift_dr = 0; update_dr = 1;
        @(negedge tck); update_dr = 0;
    endtask

    task automatic respond(logic [31:0] d);
        @(negedge tck); rsp_valid = 1; rsp_rdata = d;
        @(negedge tck); rsp_valid = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0]  ir_out;
        logic [34:0] o;
        int          ab;
        repeat (3) @(negedge tck);
        check(req_valid == 0 && abort_pulse == 0, "R5 reset outputs", {req_valid, abort_pulse}, 0);
        trst_n = 1;
        repeat (2) @(negedge tck);

        // R1 R2: reset selects identification chain
        scan_dr(32, '0, o);
        check(o[31:0] == 32'h3BA00477, "R2 idcode after reset (R1)", o, 64'h3BA00477);

        // R1 R10: IR capture pattern appears on tdo during shift-IR
        scan_ir(4'b1111, ir_out);
        check(ir_out == 4'b0001, "R10 IR capture on tdo (R1)", ir_out, 4'b0001);

        // R3: bypass, one-bit delay
        scan_dr(8, 35'h0B2, o);
        check(o[7:0] == {7'h32, 1'b0}, "R3 bypass 1111", o[7:0], {7'h32, 1'b0});
        scan_ir(4'b0000, ir_out);
        scan_dr(8, 35'h0C5, o);
        check(o[7:0] == {7'h45, 1'b0}, "R3 unknown 0000", o[7:0], {7'h45, 1'b0});
        scan_ir(4'b0101, ir_out);
        scan_dr(8, 35'h07E, o);
        check(o[7:0] == {7'h7E, 1'b0}, "R3 unknown 0101", o[7:0], {7'h7E, 1'b0});

        // R4 R6: debug-port write, ack OK with zero data
        scan_ir(4'b1010, ir_out);
        exp_q.push_back({1'b0, 2'b01, 1'b0, 32'hCAFE1234});
        scan_dr(35, {32'hCAFE1234, 2'b01, 1'b0}, o);
        check(o == {32'h0, 3'b010}, "R6 first ack OK", o, {32'h0, 3'b010});

        // R7: no response yet, wait ack and no request
        scan_dr(35, {32'h11112222, 2'b10, 1'b1}, o);
        check(o[2:0] == 3'b001, "R7 wait ack", o[2:0], 3'b001);
        respond(32'hA5A50001);

        // R4 R6: access-port read after response
        scan_ir(4'b1011, ir_out);
        exp_q.push_back({1'b1, 2'b11, 1'b1, 32'h0});
        scan_dr(35, {32'h0, 2'b11, 1'b1}, o);
        check(o == {32'hA5A50001, 3'b010}, "R6 read data and OK", o, {32'hA5A50001, 3'b010});
        respond(32'h13579BDF);
        exp_q.push_back({1'b1, 2'b00, 1'b0, 32'h89ABCDEF});
        scan_dr(35, {32'h89ABCDEF, 2'b00, 1'b0}, o);
        check(o == {32'h13579BDF, 3'b010}, "R6 second read data", o, {32'h13579BDF, 3'b010});

        // R8: abort with bit 0 clear has no effect, set gives one pulse
        scan_ir(4'b1000, ir_out);
        ab = abort_cnt;
        scan_dr(32, 35'h0, o);
        @(negedge tck);
        check(abort_cnt == ab, "R8 abort bit clear", abort_cnt, ab);
        check(o[31:0] == 32'h0, "R8 abort capture zero", o[31:0], 0);
        scan_dr(32, 35'h1, o);
        @(negedge tck);
        check(abort_cnt == ab + 1, "R8 single abort pulse", abort_cnt, ab + 1);

        // R8 R9: abort ended the outstanding request
        scan_ir(4'b1010, ir_out);
        exp_q.push_back({1'b0, 2'b10, 1'b1, 32'h00000000});
        scan_dr(35, {32'h0, 2'b10, 1'b1}, o);
        check(o[2:0] == 3'b010, "R9 ack OK after abort", o[2:0], 3'b010);
        respond(32'h0BADF00D);

        // R9: response while idle is ignored
        respond(32'hDEADBEEF);
        exp_q.push_back({1'b0, 2'b00, 1'b0, 32'h55AA55AA});
        scan_dr(35, {32'h55AA55AA, 2'b00, 1'b0}, o);
        check(o == {32'h0BADF00D, 3'b010}, "R9 idle response ignored", o, {32'h0BADF00D, 3'b010});
        respond(32'h00000042);

        // R5: identification scan issues no request
        scan_ir(4'b1110, ir_out);
        scan_dr(32, 35'h7, o);
        check(o[31:0] == 32'h3BA00477, "R2 idcode selected", o[31:0], 64'h3BA00477);
        repeat (3) @(negedge tck);
        check(exp_q.size() == 0, "R5 all requests seen", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule